// File: doc/BRIEF.md
# Bitstream and Index Helper Unit

This execution unit evaluates one of four auxiliary signal-processing operations per cycle and presents a registered 32-bit result one clock after the request. An opcode picks the operation, and two 32-bit operands feed it. A 6-bit position value and a 6-bit size value from a control register also feed it. The control register itself is written elsewhere. So are instruction fetch and branch targets.

The four operations are as follows. A branch-condition test reports whether the position value has reached 32. This is used to decide when a bitstream reader should fetch another word. A circular-buffer index step subtracts a step from an index, and when the index has reached zero it reloads a maximum instead; the step and the maximum share one packed operand. A variable insert writes a field whose position and width come from the control values rather than from the instruction. A reversal mirrors the low sixteen bits, which is the addressing step used for FFT buffer reordering.

Top module: `dsp_aux_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `out_valid`=0, `result`=0 and `branch_taken`=0.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high.
- R3: Opcode 2'b00 (branch test) gives `branch_taken`=1 exactly when `pos` >= 32, and gives `result`=0.
- R4: Any opcode other than 2'b00 gives `branch_taken`=0.
- R5: Opcode 2'b01 (circular step) with `opa` (the index) non-zero gives `opa` minus `opb[7:0]`, computed modulo 2^32.
- R6: Opcode 2'b01 with `opa`=0 gives `opb[23:8]` zero-extended to 32 bits.
- R7: For opcode 2'b01, `opb[31:24]` has no effect on the result.
- R8: Opcode 2'b10 (insert) with 1 <= `size` and `pos`+`size` <= 32 gives `opb` with bits `pos`..`pos`+`size`-1 replaced by `opa[size-1:0]`. All other bits of `opb` pass through unchanged.
- R9: Opcode 2'b10 with `size`=0, or with `pos`+`size` > 32, gives `opb` unchanged.
- R10: Opcode 2'b10 with `pos`=0 and `size`=32 gives `opa` in full.
- R11: Opcode 2'b11 (reverse) gives `result[15-i]` = `opa[i]` for i in 0..15, and `result[31:16]`=0.
- R12: In a cycle after one with `in_valid` low, `result` and `branch_taken` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | Operation select: 00 branch test, 01 circular step, 10 insert, 11 reverse |
| opa | input | 32 | Index, insert source, or value to reverse |
| opb | input | 32 | Packed step/maximum, or insert destination |
| pos | input | 6 | Control-register position value |
| size | input | 6 | Control-register field width |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 32 | Registered result |
| branch_taken | output | 1 | Registered branch-condition flag |

## Verification
The bench tests the branch threshold at positions 31, 32 and 63. A comparison one bit too narrow, or an off-by-one, would flip the flag at one of these points. It runs the circular step with a zero index, and with garbage in the top byte of the packed operand. A design that always subtracts would fail these cases. So would a design that takes the maximum from the wrong bits. For insert, the bench covers a zero width, a field that spills past bit 31, a full 32-bit field, and a 1-bit field at bit 31. These are where a mask built in 32 bits overflows or silently wraps. The reversal input has set upper bits, so a design that failed to clear them would show nonzero upper bits in the result.

// File: rtl/dsp_aux_pkg.sv
package dsp_aux_pkg;
  localparam int DATA_W  = 32;
  localparam int FIELD_W = 6;
  localparam int STEP_W  = 8;
  localparam int MAX_W   = 16;
  localparam int REV_W   = 16;

  typedef enum logic [1:0] {
    OP_BRANCH = 2'b00,
    OP_CIRC   = 2'b01,
    OP_INSERT = 2'b10,
    OP_REV    = 2'b11
  } aux_op_e;
endpackage

// File: rtl/aux_circ_index.sv
module aux_circ_index #(
  parameter int DATA_W = 32,
  parameter int STEP_W = 8,
  parameter int MAX_W  = 16
) (
  input  logic [DATA_W-1:0] index_in,
  input  logic [DATA_W-1:0] packed_in,
  output logic [DATA_W-1:0] index_out
);
  localparam int TOP_BIT = STEP_W + MAX_W;

  logic [STEP_W-1:0] step;
  logic [MAX_W-1:0]  wrap_max;
  logic [DATA_W-TOP_BIT-1:0] unused_hi;

  assign step      = packed_in[STEP_W-1:0];
  assign wrap_max  = packed_in[TOP_BIT-1:STEP_W];
  assign unused_hi = packed_in[DATA_W-1:TOP_BIT];

  always_comb begin
    if (index_in == '0) index_out = DATA_W'(wrap_max);
    else                index_out = index_in - DATA_W'(step);
  end
endmodule

// File: rtl/aux_bit_insert.sv
module aux_bit_insert #(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 6
) (
  input  logic [DATA_W-1:0]  src,
  input  logic [DATA_W-1:0]  dst,
  input  logic [FIELD_W-1:0] pos,
  input  logic [FIELD_W-1:0] size,
  output logic [DATA_W-1:0]  merged
);
  localparam int SUM_W  = FIELD_W + 1;
  localparam int WIDE_W = 2 * DATA_W;

  logic [SUM_W-1:0]  span;
  logic              fits;
  logic [WIDE_W-1:0] mask_wide;
  logic [WIDE_W-1:0] src_wide;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] unused_wide_hi;

  assign span = SUM_W'(pos) + SUM_W'(size);
  assign fits = (size != '0) && (span <= SUM_W'(DATA_W));

  always_comb begin
    mask_wide = ((WIDE_W'(1) << size) - WIDE_W'(1)) << pos;
    src_wide  = WIDE_W'(src) << pos;
  end

  assign mask           = mask_wide[DATA_W-1:0];
  assign shifted        = src_wide[DATA_W-1:0];
  assign unused_wide_hi = mask_wide[WIDE_W-1:DATA_W] ^ src_wide[WIDE_W-1:DATA_W];

  assign merged = fits ? ((dst & ~mask) | (shifted & mask)) : dst;
endmodule

// File: rtl/aux_bit_rev.sv
module aux_bit_rev #(
  parameter int DATA_W = 32,
  parameter int REV_W  = 16
) (
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] mirrored
);
  logic [DATA_W-REV_W-1:0] unused_hi;
  assign unused_hi = src[DATA_W-1:REV_W];

  for (genvar i = 0; i < REV_W; i++) begin : g_rev
    assign mirrored[i] = src[REV_W-1-i];
  end
  assign mirrored[DATA_W-1:REV_W] = '0;
endmodule

// File: rtl/dsp_aux_unit.sv
module dsp_aux_unit
  import dsp_aux_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [1:0]          op,
  input  logic [DATA_W-1:0]   opa,
  input  logic [DATA_W-1:0]   opb,
  input  logic [FIELD_W-1:0]  pos,
  input  logic [FIELD_W-1:0]  size,
  output logic                out_valid,
  output logic [DATA_W-1:0]   result,
  output logic                branch_taken
);
  logic [DATA_W-1:0] circ_res;
  logic [DATA_W-1:0] ins_res;
  logic [DATA_W-1:0] rev_res;
  logic [DATA_W-1:0] next_res;
  logic              next_taken;
  aux_op_e           op_sel;

  assign op_sel = aux_op_e'(op);

  aux_circ_index #(.DATA_W(DATA_W), .STEP_W(STEP_W), .MAX_W(MAX_W)) u_circ (
    .index_in (opa),
    .packed_in(opb),
    .index_out(circ_res)
  );

  aux_bit_insert #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_ins (
    .src   (opa),
    .dst   (opb),
    .pos   (pos),
    .size  (size),
    .merged(ins_res)
  );

  aux_bit_rev #(.DATA_W(DATA_W), .REV_W(REV_W)) u_rev (
    .src     (opa),
    .mirrored(rev_res)
  );

  always_comb begin
    next_res   = '0;
    next_taken = 1'b0;
    unique case (op_sel)
      OP_BRANCH: next_taken = (pos >= FIELD_W'(DATA_W));
      OP_CIRC:   next_res   = circ_res;
      OP_INSERT: next_res   = ins_res;
      OP_REV:    next_res   = rev_res;
      default:   next_res   = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      result       <= '0;
      branch_taken <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result       <= next_res;
        branch_taken <= next_taken;
      end
    end
  end

  // R1: outputs cleared after a reset edge
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && !branch_taken));

  // R2: valid follows the request by one cycle
  a_r2_valid_follow: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3: branch test gives a zero result
  a_r3_branch_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b00) |=> (result == '0));

  // R4: non-branch operations never raise the flag
  a_r4_no_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op != 2'b00) |=> !branch_taken);

  // R6: zero index reloads the packed maximum
  a_r6_wrap_reload: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b01 && opa == '0) |=>
      (result == DATA_W'($past(opb[STEP_W+MAX_W-1:STEP_W]))));

  // R9: an empty insert leaves the destination as it was
  a_r9_empty_insert: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b10 && size == '0) |=> (result == $past(opb)));

  // R11: reversal clears the upper half
  a_r11_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b11) |=> (result[DATA_W-1:REV_W] == '0));

  // R12: idle cycles hold the outputs
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(branch_taken)));
endmodule

// File: tb/dsp_aux_unit_tb.sv
module dsp_aux_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  op;
  logic [31:0] opa, opb;
  logic [5:0]  pos, size;
  logic        out_valid;
  logic [31:0] result;
  logic        branch_taken;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_res_q[$];
  logic        exp_tk_q[$];
  string       exp_tag_q[$];

  logic [31:0] last_res;
  logic        last_tk;
  bit          track_idle = 1'b0;

  always #4 clk = ~clk;

  dsp_aux_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .opa(opa), .opb(opb), .pos(pos), .size(size),
    .out_valid(out_valid), .result(result), .branch_taken(branch_taken)
  );

  function automatic logic [31:0] model_res(input logic [1:0] o, input logic [31:0] a,
      input logic [31:0] b, input int p, input int s);
    logic [31:0] r;
    r = 32'h0;
    case (o)
      2'b00: r = 32'h0;
      2'b01: r = (a == 0) ? {16'h0, b[23:8]} : a - {24'h0, b[7:0]};
      2'b10: begin
        r = b;
        if (s != 0 && p + s <= 32)
          for (int k = 0; k < s; k++) r[p+k] = a[k];
      end
      default: for (int k = 0; k < 16; k++) r[15-k] = a[k];
    endcase
    return r;
  endfunction

  task automatic send(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
      input int p, input int s, input string tag);
    @(negedge clk);
    in_valid = 1'b1; op = o; opa = a; opb = b; pos = 6'(p); size = 6'(s);
    exp_res_q.push_back(model_res(o, a, b, p, s));
    exp_tk_q.push_back(o == 2'b00 && p >= 32);
    exp_tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0; opa = 32'hDEAD_BEEF; opb = 32'h1234_5678; op = 2'b01;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && track_idle) begin
      if (out_valid) begin
        checks++;
        if (exp_res_q.size() == 0) begin
          errors++;
          $display("FAIL R2: result with no request pending, actual valid=1 expected valid=0");
        end else begin
          logic [31:0] er; logic et; string tg;
          er = exp_res_q.pop_front(); et = exp_tk_q.pop_front(); tg = exp_tag_q.pop_front();
          if (result !== er || branch_taken !== et) begin
            errors++;
            $display("FAIL %s: actual result=%h taken=%b expected result=%h taken=%b",
                     tg, result, branch_taken, er, et);
          end
        end
      end else begin
        checks++; // R12: outputs hold while idle
        if (result !== last_res || branch_taken !== last_tk) begin
          errors++;
          $display("FAIL R12: actual result=%h taken=%b expected result=%h taken=%b",
                   result, branch_taken, last_res, last_tk);
        end
      end
      last_res = result;
      last_tk  = branch_taken;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b1; op = 2'b01; opa = 32'h5; opb = 32'hFF01; pos = 0; size = 0;
    repeat (3) @(negedge clk);
    checks++; // R1
    if (out_valid !== 1'b0 || result !== 32'h0 || branch_taken !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual v=%b r=%h t=%b expected v=0 r=0 t=0", out_valid, result, branch_taken);
    end
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    last_res = 32'h0; last_tk = 1'b0; track_idle = 1'b1;
    idle(2);

    send(2'b00, 32'h0, 32'h0, 31, 0, "R3");   // R3 just below threshold
    send(2'b00, 32'h0, 32'h0, 32, 0, "R3");   // R3 at threshold
    idle(1);
    send(2'b00, 32'hFFFF_FFFF, 32'h0, 63, 5, "R3");
    send(2'b00, 32'h0, 32'h0, 0, 0, "R3");
    send(2'b10, 32'hFFFF_FFFF, 32'h0, 40, 0, "R4"); // R4 high pos, non-branch op
    send(2'b01, 32'd5, 32'h0000_1202, 0, 0, "R5");
    send(2'b01, 32'd1, 32'h0000_0003, 0, 0, "R5");  // wraps below zero modulo 2^32
    send(2'b01, 32'h0, 32'h0012_3404, 0, 0, "R6");
    send(2'b01, 32'h0, 32'hAB12_3404, 0, 0, "R7");
    send(2'b01, 32'd100, 32'h5500_0A07, 0, 0, "R7");
    idle(2);
    send(2'b10, 32'h0000_ABCD, 32'hFFFF_0000, 4, 8, "R8");
    send(2'b10, 32'h0000_0001, 32'h0000_0000, 31, 1, "R8");
    send(2'b10, 32'h1234_5678, 32'hFFFF_FFFF, 8, 24, "R8");
    send(2'b10, 32'h1234_5678, 32'hCAFE_F00D, 5, 0, "R9");
    send(2'b10, 32'h0000_00FF, 32'hCAFE_F00D, 28, 8, "R9");
    send(2'b10, 32'hFFFF_FFFF, 32'h1357_9BDF, 33, 1, "R9");
    send(2'b10, 32'h8765_4321, 32'h0F0F_0F0F, 0, 32, "R10");
    send(2'b11, 32'hFFFF_0001, 32'h0, 0, 0, "R11");
    send(2'b11, 32'h1234_A5C3, 32'h0, 0, 0, "R11");
    idle(3);

    if (exp_res_q.size() != 0) begin
      errors++;
      $display("FAIL R2: actual %0d results missing expected 0", exp_res_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule